// File: doc/BRIEF.md
# Memory Alignment Predictor

This block tells the memory issue logic, for each load or store it is about to send, whether to issue it as one access or as two partial accesses. The prediction is looked up by instruction address in a small fully associative table holding the addresses of instructions that were earlier found to be misaligned. An address missing from the table is predicted aligned. An opcode that is explicitly marked as a misaligned access is always predicted split. The prediction comes out in the same cycle as the lookup. It consists of a split flag and a micro-op count: 2 for a split access and 1 for a single access.

When the memory stage later resolves an access, it reports whether the access was actually misaligned and what prediction it was issued with. If an access issued as a single access turns out to be misaligned, the block raises `replay` in that same cycle so the pipeline can flush and re-issue the access. It also learns the instruction's address. A two-state training machine handles learning. In **TR_IDLE**, the transition *capture* (taken on any mispredict) latches the instruction tag and moves to **TR_INSTALL**. In **TR_INSTALL**, the latched tag is written into the table unless it is already present. The transition *chain* (another mispredict in the same cycle) re-captures and stays in TR_INSTALL. The transition *done* (no mispredict) returns to TR_IDLE. Victims are chosen round-robin. A reset empties the table.

Top module: `align_predictor`

## Requirements
- R1: After reset every table entry is invalid, so any non-explicit lookup is predicted single (`pred_split`=0, `pred_uops`=1).
- R2: A valid lookup that is not explicit and whose tag is not in the table gives `pred_split`=0 and `pred_uops`=1.
- R3: A valid lookup with `lk_explicit`=1 gives `pred_split`=1 and `pred_uops`=2, whatever the table holds.
- R4: A valid lookup whose tag is in the table gives `pred_split`=1 and `pred_uops`=2.
- R5: `replay` is 1 in the same cycle exactly when `rs_valid`=1, `rs_pred_split`=0 and `rs_misaligned`=1; otherwise it is 0.
- R6: When `replay` is 1 at clock edge k, the resolved tag is latched at edge k and written at edge k+1. Lookups in the cycle after edge k+1 hit it; a lookup between edges k and k+1 does not.
- R7: A resolved access that was predicted split and is aligned, or any resolve without `replay`, leaves the table unchanged.
- R8: A new tag replaces entries in round-robin order starting at entry 0, so with 4 entries the fifth distinct learned tag evicts the first.
- R9: A mispredicted tag that is already in the table is not written again and does not advance the replacement pointer.
- R10: With `lk_valid`=0, `pred_split`=0 and `pred_uops`=0.
- R11: The tag is the instruction address without its `PC_LSB` low bits (2 by default), so addresses differing only in those bits match the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A memory instruction is being looked up |
| lk_pc | input | PC_W | Instruction address of the lookup |
| lk_explicit | input | 1 | Opcode is an explicit misaligned access |
| pred_split | output | 1 | Issue as two partial accesses |
| pred_uops | output | 2 | Micro-op count: 0 idle, 1 single, 2 split |
| rs_valid | input | 1 | An access is being resolved |
| rs_pc | input | PC_W | Instruction address of the resolved access |
| rs_pred_split | input | 1 | Prediction the access was issued with |
| rs_misaligned | input | 1 | Resolved access was actually misaligned |
| replay | output | 1 | Flush and re-issue the resolved access |

## Verification
On every cycle, the assertions check the following: an explicit opcode is predicted split, an idle lookup port gives zeros, a split-predicted resolve never replays, the training machine captures the tag after every mispredict, the table never holds the same tag twice, and the table holds still whenever no write is requested. Only the bench scenarios can show the learning latency itself, the eviction order across a full table, whether a duplicate mispredict advances the pointer, and the low-bit masking of addresses, because each of these needs a sequence of resolves followed by lookups.

// File: rtl/align_pred_pkg.sv
package align_pred_pkg;

    typedef enum logic [0:0] {
        TR_IDLE    = 1'b0,
        TR_INSTALL = 1'b1
    } train_state_e;

endpackage

// File: rtl/ap_tag_table.sv
module ap_tag_table #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 30,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic [TAG_W-1:0] chk_tag,
    output logic             chk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] chk_match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                valid_q[e] <= 1'b1;
                tag_q[e]   <= wr_tag;
            end
        end

        assign lk_match[e]  = valid_q[e] && (tag_q[e] == lk_tag);
        assign chk_match[e] = valid_q[e] && (tag_q[e] == chk_tag);
    end

    assign lk_hit  = |lk_match;
    assign chk_hit = |chk_match;

    // R1: reset leaves every entry invalid
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R9: duplicate filtering keeps at most one matching entry
    assert_unique_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R7: without a write request the table holds its contents
    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/ap_rr_victim.sv
module ap_rr_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (ptr_q == IDX_W'(ENTRIES - 1)) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign victim = ptr_q;

endmodule

// File: rtl/ap_train_fsm.sv
module ap_train_fsm
    import align_pred_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mispredict,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             dup_hit,
    output logic [TAG_W-1:0] cap_tag,
    output logic             wr_en
);

    train_state_e     state_q, state_d;
    logic [TAG_W-1:0] cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TR_IDLE:    state_d = mispredict ? TR_INSTALL : TR_IDLE;
            TR_INSTALL: state_d = mispredict ? TR_INSTALL : TR_IDLE;
            default:    state_d = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TR_IDLE;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (mispredict) begin
                cap_q <= miss_tag;
            end
        end
    end

    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            TR_IDLE:    wr_en = 1'b0;
            TR_INSTALL: wr_en = !dup_hit;
            default:    wr_en = 1'b0;
        endcase
    end

    assign cap_tag = cap_q;

    // R6: every mispredict is captured for installation on the next cycle
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> (state_q == TR_INSTALL) && (cap_q == $past(miss_tag)));

endmodule

// File: rtl/align_predictor.sv
module align_predictor #(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_explicit,
    output logic            pred_split,
    output logic [1:0]      pred_uops,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_pred_split,
    input  logic            rs_misaligned,
    output logic            replay
);

    localparam int TAG_W = PC_W - PC_LSB;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [TAG_W-1:0] lk_tag;
    logic [TAG_W-1:0] rs_tag;
    logic [TAG_W-1:0] cap_tag;
    logic             lk_hit;
    logic             dup_hit;
    logic             wr_en;
    logic [IDX_W-1:0] victim;
    logic             mispredict;

    assign lk_tag     = lk_pc[PC_W-1:PC_LSB];
    assign rs_tag     = rs_pc[PC_W-1:PC_LSB];
    assign mispredict = rs_valid && !rs_pred_split && rs_misaligned;

    ap_tag_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_tag  (lk_tag),
        .lk_hit  (lk_hit),
        .chk_tag (cap_tag),
        .chk_hit (dup_hit),
        .wr_en   (wr_en),
        .wr_idx  (victim),
        .wr_tag  (cap_tag)
    );

    ap_rr_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (wr_en),
        .victim  (victim)
    );

    ap_train_fsm #(
        .TAG_W (TAG_W)
    ) u_train (
        .clk        (clk),
        .rst_n      (rst_n),
        .mispredict (mispredict),
        .miss_tag   (rs_tag),
        .dup_hit    (dup_hit),
        .cap_tag    (cap_tag),
        .wr_en      (wr_en)
    );

    always_comb begin
        pred_split = 1'b0;
        pred_uops  = 2'd0;
        if (lk_valid) begin
            pred_split = lk_explicit || lk_hit;
            pred_uops  = (lk_explicit || lk_hit) ? 2'd2 : 2'd1;
        end
    end

    assign replay = mispredict;

    // R3: explicit misaligned opcodes are always split
    assert_explicit_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_explicit) |-> (pred_split && pred_uops == 2'd2));

    // R10: idle lookup port drives zeros
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!pred_split && pred_uops == 2'd0));

    // R5: a resolve issued as split never replays
    assert_split_no_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_pred_split) |-> !replay);

endmodule

// File: tb/align_predictor_tb.sv
`timescale 1ns/1ps
module align_predictor_tb;

    typedef struct packed {
        logic        lkv;
        logic        lkx;
        logic [31:0] lkpc;
        logic        rsv;
        logic [31:0] rspc;
        logic        rsps;
        logic        rsmis;
        logic        esplit;
        logic [1:0]  euops;
        logic        erep;
    } vec_t;

    localparam int NV = 29;
    // A=100 B=200 C=300 D=400 E=500 F=600 (hex)
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,32'h100, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 0  R2 miss
        '{1'b1,1'b1,32'h100, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 1  R3 explicit
        '{1'b0,1'b0,32'h0,   1'b1,32'h100,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 2  R5 R10 mispredict A
        '{1'b1,1'b0,32'h100, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 3  R6 not yet
        '{1'b1,1'b0,32'h100, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 4  R4 R6 learned
        '{1'b1,1'b0,32'h102, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 5  R11 low bits
        '{1'b1,1'b0,32'h200, 1'b1,32'h200,1'b1,1'b0, 1'b0,2'd1,1'b0}, // 6  R7 split/aligned
        '{1'b0,1'b0,32'h0,   1'b0,32'h300,1'b0,1'b1, 1'b0,2'd0,1'b0}, // 7  R5 no valid
        '{1'b1,1'b0,32'h200, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 8  R7 unchanged
        '{1'b0,1'b0,32'h0,   1'b1,32'h200,1'b0,1'b0, 1'b0,2'd0,1'b0}, // 9  R5 aligned ok
        '{1'b0,1'b0,32'h0,   1'b1,32'h300,1'b1,1'b1, 1'b0,2'd0,1'b0}, // 10 R5 split ok
        '{1'b1,1'b0,32'h300, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 11 R7 C not learned
        '{1'b0,1'b0,32'h0,   1'b1,32'h200,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 12 learn B
        '{1'b0,1'b0,32'h0,   1'b1,32'h300,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 13 learn C
        '{1'b0,1'b0,32'h0,   1'b1,32'h400,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 14 learn D
        '{1'b0,1'b0,32'h0,   1'b1,32'h500,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 15 learn E
        '{1'b0,1'b0,32'h0,   1'b1,32'h200,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 16 R9 dup B
        '{1'b0,1'b0,32'h0,   1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd0,1'b0}, // 17
        '{1'b0,1'b0,32'h0,   1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd0,1'b0}, // 18
        '{1'b1,1'b0,32'h100, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 19 R8 A evicted
        '{1'b1,1'b0,32'h500, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 20 R8 E present
        '{1'b1,1'b0,32'h200, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 21 R4 B
        '{1'b1,1'b0,32'h400, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 22 R4 D
        '{1'b1,1'b0,32'h300, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 23 R4 C
        '{1'b0,1'b0,32'h0,   1'b1,32'h600,1'b0,1'b1, 1'b0,2'd0,1'b1}, // 24 learn F
        '{1'b0,1'b0,32'h0,   1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd0,1'b0}, // 25
        '{1'b1,1'b0,32'h600, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}, // 26 R8 F in
        '{1'b1,1'b0,32'h200, 1'b0,32'h0,  1'b0,1'b0, 1'b0,2'd1,1'b0}, // 27 R9 B evicted
        '{1'b1,1'b1,32'h300, 1'b0,32'h0,  1'b0,1'b0, 1'b1,2'd2,1'b0}  // 28 R3 explicit+hit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_explicit = 1'b0;
    logic        pred_split;
    logic [1:0]  pred_uops;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_pred_split = 1'b0;
    logic        rs_misaligned = 1'b0;
    logic        replay;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    align_predictor u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_pc         (lk_pc),
        .lk_explicit   (lk_explicit),
        .pred_split    (pred_split),
        .pred_uops     (pred_uops),
        .rs_valid      (rs_valid),
        .rs_pc         (rs_pc),
        .rs_pred_split (rs_pred_split),
        .rs_misaligned (rs_misaligned),
        .replay        (replay)
    );

    task automatic check(input string req, input logic es, input logic [1:0] eu,
                         input logic er);
        n_checks++;
        if (pred_split !== es || pred_uops !== eu || replay !== er) begin
            n_fail++;
            $display("FAIL %s: split/uops/replay got %0b/%0d/%0b expected %0b/%0d/%0b",
                     req, pred_split, pred_uops, replay, es, eu, er);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        lk_valid      = v.lkv;
        lk_explicit   = v.lkx;
        lk_pc         = v.lkpc;
        rs_valid      = v.rsv;
        rs_pc         = v.rspc;
        rs_pred_split = v.rsps;
        rs_misaligned = v.rsmis;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table right after reset
        apply('{1'b1,1'b0,32'h100, 1'b0,32'h0,1'b0,1'b0, 1'b0,2'd1,1'b0});
        check("R1", 1'b0, 2'd1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("vector %0d", i), VECS[i].esplit, VECS[i].euops, VECS[i].erep);
        end

        // R1: reset in mid-run forgets learned F
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        apply('{1'b1,1'b0,32'h600, 1'b0,32'h0,1'b0,1'b0, 1'b0,2'd1,1'b0});
        check("R1 after reset", 1'b0, 2'd1, 1'b0);

        // R11: learned address with offset 3 matches the aligned lookup
        apply('{1'b0,1'b0,32'h0, 1'b1,32'h703,1'b0,1'b1, 1'b0,2'd0,1'b1});
        check("R11 learn", 1'b0, 2'd0, 1'b1);
        apply('{1'b0,1'b0,32'h0, 1'b0,32'h0,1'b0,1'b0, 1'b0,2'd0,1'b0});
        apply('{1'b1,1'b0,32'h700, 1'b0,32'h0,1'b0,1'b0, 1'b0,2'd1,1'b0});
        check("R11 hit", 1'b1, 2'd2, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule